// File: doc/BRIEF.md
# MDIO Management Read Master

This block fetches one 16-bit register from an external PHY over the two-wire management interface. A single-cycle `start` strobe, taken while the block is idle, captures a 5-bit PHY address, a 5-bit register address and a preamble choice. The block then drives the management clock `mdc` and the data line, which is split into `mdio_o`, `mdio_oe` and `mdio_i`. If the preamble is requested, the frame opens with 32 ones. A 16-bit read header follows, most significant bit first. The block then releases the line for 20 clock periods and samples the PHY's reply. When the frame ends, the register value appears on `rd_data` and `done` pulses for one cycle.

Each bit takes `2*HALF` system clocks: `HALF` with `mdc` low, then `HALF` with `mdc` high. `HALF` is the smallest whole number for which `CLK_HZ/(2*HALF)` does not exceed `MDC_MAX_HZ`, so both halves are equal and the management clock never runs faster than 2.5 MHz. Data is launched at the start of the low half. The input is sampled on the system clock edge that raises `mdc`.

The controlling state machine has four states. IDLE goes to PRE on `start` when `preamble_on` is 1, or to HDR on `start` when it is 0. PRE goes to HDR after its 32nd bit. HDR goes to CAP after its 16th bit. CAP goes back to IDLE after its 20th bit, and that transition raises `done`. Every bit boundary falls at the end of a high half of `mdc`.

Top module: `mdio_rd_master`

## Requirements
- R1: After reset and whenever the block is idle, `mdc`, `mdio_oe`, `mdio_o`, `busy` and `done` are 0. `rd_data` is 0 until the first frame completes.
- R2: A `start` seen at a clock edge while `busy` is 0 is accepted. `busy` is 1 from the next cycle until the frame ends. `phy_addr`, `reg_addr` and `preamble_on` are taken at that edge.
- R3: A `start` seen while `busy` is 1 is ignored. Changes to `phy_addr`, `reg_addr` or `preamble_on` during a frame alter neither the bits sent nor the data returned.
- R4: Each bit lasts `2*HALF` cycles, with `mdc` low for the first `HALF` cycles and high for the last `HALF` cycles. `HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ))`.
- R5: With `preamble_on` = 1, the frame begins with 32 bits in which `mdio_oe` = 1 and `mdio_o` = 1. With `preamble_on` = 0, there are no such bits.
- R6: Next come 16 header bits with `mdio_oe` = 1, sent MSB first, of value `16'hD800 | phy_addr<<5 | reg_addr`. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R7: After the header, `mdio_oe` is 0 for 20 bits, and `mdio_o` is 0 whenever `mdio_oe` is 0. `mdio_i` is sampled once per bit, on the edge at which `mdc` rises.
- R8: Number those 20 samples 0 to 19 in arrival order. `rd_data` receives samples 3 through 18, with sample 3 as bit 15. Samples 0, 1, 2 and 19 are discarded.
- R9: `done` is 1 for exactly one cycle: the cycle after the last high half, in which `busy` is already 0 and `rd_data` holds the new value. `rd_data` stays unchanged outside `done` cycles.
- R10: A `start` given in the same cycle as `done` is accepted, so `busy` is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a read frame |
| preamble_on | input | 1 | Send 32 preamble ones before the header |
| phy_addr | input | 5 | PHY address placed in the header |
| reg_addr | input | 5 | Register address placed in the header |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when rd_data is valid |
| rd_data | output | 16 | Last register value read |

## Verification
Two functions can coincide at the end of a frame. The completion pulse with its result update can arrive in the same cycle as a new request, and a new request can also arrive in the middle of a frame while the address inputs are changing. The bench drives `start` in the exact `done` cycle and checks that `busy` rises on the next cycle while the old result stays intact. It also raises `start` with different addresses and preamble choice part way through a frame. In that case the bit stream, compared cycle by cycle with a timeline model, and the returned data must both belong to the first request only.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 16;
    localparam int CAP_BITS = 20;

    // capture window inside the 20 sampled bits
    localparam int KEEP_FIRST = 3;
    localparam int KEEP_LAST  = KEEP_FIRST + DATA_W - 1;

    localparam int MAX_BITS = (PRE_BITS > CAP_BITS) ?
                              ((PRE_BITS > HDR_BITS) ? PRE_BITS : HDR_BITS) :
                              ((CAP_BITS > HDR_BITS) ? CAP_BITS : HDR_BITS);
    localparam int CNT_W = $clog2(MAX_BITS);

    // leading ones, start pattern and read opcode ahead of the two addresses
    localparam logic [HDR_BITS-2*ADDR_W-1:0] HDR_LEAD = 6'b110110;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_HDR  = 2'd2,
        ST_CAP  = 2'd3
    } mdio_state_e;

    function automatic logic [HDR_BITS-1:0] make_header(
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad
    );
        return {HDR_LEAD, phy, regad};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);

    logic wrap;

    generate
        if (HALF <= 1) begin : g_direct
            // every system cycle is a half period
            assign wrap = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            localparam logic [CW-1:0] LAST = CW'(HALF - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign wrap = (cnt == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mdc <= 1'b0;
        end else if (wrap) begin
            mdc <= ~mdc;
        end
    end

    assign rise = run && wrap && !mdc;
    assign fall = run && wrap && mdc;

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         bit_o
);

    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign bit_o = sreg[W-1];

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  logic         bit_i,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (sample) begin
            word <= {word[W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/mdio_rd_master.sv
module mdio_rd_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              preamble_on,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF_RAW = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CAP_LAST   = CNT_W'(CAP_BITS - 1);
    localparam logic [CNT_W-1:0] KEEP_LO    = CNT_W'(KEEP_FIRST);
    localparam logic [CNT_W-1:0] KEEP_HI    = CNT_W'(KEEP_LAST);

    mdio_state_e          state_q, state_d;
    logic [CNT_W-1:0]     bit_q, bit_d;
    logic                 run, rise, fall;
    logic                 load, finish, last_bit;
    logic                 hdr_shift, cap_keep, tx_bit;
    logic [DATA_W-1:0]    cap_word;

    assign run = (state_q != ST_IDLE);

    mdio_clk_div #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    // end of the current phase
    always_comb begin
        unique case (state_q)
            ST_PRE:  last_bit = (bit_q == PRE_LAST);
            ST_HDR:  last_bit = (bit_q == HDR_LAST);
            ST_CAP:  last_bit = (bit_q == CAP_LAST);
            default: last_bit = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        load    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    bit_d   = '0;
                    state_d = preamble_on ? ST_PRE : ST_HDR;
                end
            end
            ST_PRE: begin
                if (fall) begin
                    if (last_bit) begin
                        state_d = ST_HDR;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (fall) begin
                    if (last_bit) begin
                        state_d = ST_CAP;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            ST_CAP: begin
                if (fall) begin
                    if (last_bit) begin
                        state_d = ST_IDLE;
                        bit_d   = '0;
                        finish  = 1'b1;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                bit_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    assign hdr_shift = (state_q == ST_HDR) && fall;
    assign cap_keep  = (state_q == ST_CAP) && rise &&
                       (bit_q >= KEEP_LO) && (bit_q <= KEEP_HI);

    mdio_tx_shift #(.W(HDR_BITS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (make_header(phy_addr, reg_addr)),
        .shift    (hdr_shift),
        .bit_o    (tx_bit)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (load),
        .sample (cap_keep),
        .bit_i  (mdio_i),
        .word   (cap_word)
    );

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                rd_data <= cap_word;
            end
        end
    end

    // line outputs
    always_comb begin
        unique case (state_q)
            ST_PRE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HDR: begin
                mdio_oe = 1'b1;
                mdio_o  = tx_bit;
            end
            default: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b0;
            end
        endcase
    end

    assign busy = run;

endmodule

// File: rtl/mdio_rd_master_chk.sv
module mdio_rd_master_chk #(
    parameter int HALF = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data
);

    logic        mdc_q, busy_q;
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q   <= 1'b0;
            busy_q  <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_q  <= mdc;
            busy_q <= busy;
            if (!busy) begin
                run_len <= '0;
            end else if (mdc != mdc_q) begin
                run_len <= 16'd1;
            end else begin
                run_len <= run_len + 16'd1;
            end
        end
    end

    AST_MDC_HALF_EQUAL: assert property (@(posedge clk) disable iff (rst)
        busy_q && (mdc != mdc_q) |-> run_len == 16'(HALF)); // R4

    AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc && !mdio_oe); // R1

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> !mdio_o); // R7

    AST_OE_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> !mdc); // R6

    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        mdio_oe && $past(mdio_oe) && !$stable(mdio_o) |-> !mdc); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data)); // R9

endmodule

bind mdio_rd_master mdio_rd_master_chk #(.HALF(HALF)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/mdio_rd_master_bench.sv
module mdio_rd_master_bench;

    localparam int CLK_PERIOD = 20;
    localparam int CLK_HZ     = 50_000_000;
    localparam int MDC_MAX    = 2_500_000;
    localparam int HALF       = (CLK_HZ + 2 * MDC_MAX - 1) / (2 * MDC_MAX);
    localparam int BIT_CYC    = 2 * HALF;

    logic        clk, rst, start, preamble_on, mdio_i;
    logic [4:0]  phy_addr, reg_addr;
    logic        mdc, mdio_o, mdio_oe, busy, done;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    mdio_rd_master #(.CLK_HZ(CLK_HZ), .MDC_MAX_HZ(MDC_MAX)) u_mdio_rd_master (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .preamble_on (preamble_on),
        .phy_addr    (phy_addr),
        .reg_addr    (reg_addr),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // timeline model of the frame
    bit          m_active = 1'b0;
    bit          m_done   = 1'b0;
    int          m_k      = 0;
    int          m_npre   = 0;
    logic [15:0] m_hdr    = '0;
    logic [15:0] m_data   = '0;
    logic [3:0]  m_junk   = '0;
    logic [15:0] m_rd     = '0;
    logic [15:0] nx_data  = '0;
    logic [3:0]  nx_junk  = '0;

    always @(posedge clk) begin : model
        bit was;
        if (rst) begin
            m_active = 1'b0;
            m_done   = 1'b0;
            m_k      = 0;
            m_rd     = '0;
        end else begin
            was    = m_active;
            m_done = 1'b0;
            if (was) begin
                m_k++;
                if (m_k == (m_npre + 36) * BIT_CYC) begin
                    m_active = 1'b0;
                    m_done   = 1'b1;
                    m_rd     = m_data;
                end
            end else if (start) begin
                m_active = 1'b1;
                m_k      = 0;
                m_npre   = preamble_on ? 32 : 0;
                m_hdr    = 16'hD800 | (16'(phy_addr) << 5) | 16'(reg_addr);
                m_data   = nx_data;
                m_junk   = nx_junk;
            end
        end
    end

    // reply bit for sample c: c 0..2 junk, 3..18 data MSB first, 19 junk
    function automatic logic reply_bit(input int c);
        if (c < 3)   return m_junk[3 - c];
        if (c <= 18) return m_data[15 - (c - 3)];
        return m_junk[0];
    endfunction

    // compare on every cycle and act as PHY responder
    always @(negedge clk) begin : compare
        int b, p, hb;
        logic e_mdc, e_oe, e_mdo;
        string tag;
        if (m_active) begin
            b = m_k / BIT_CYC;
            p = m_k % BIT_CYC;
            hb = b - m_npre;
            e_mdc = (p >= HALF);
            e_oe  = (b < m_npre + 16);
            if (b < m_npre) begin
                e_mdo = 1'b1; tag = "R5 preamble";
            end else if (hb < 16) begin
                e_mdo = m_hdr[15 - hb]; tag = "R6 header";
            end else begin
                e_mdo = 1'b0; tag = "R7 released";
            end
            mdio_i = (hb >= 16) ? reply_bit(hb - 16) : 1'b1;
        end else begin
            e_mdc = 1'b0; e_oe = 1'b0; e_mdo = 1'b0; tag = "R1 idle";
            mdio_i = 1'b1;
        end
        if (!rst) begin
            chk("R4 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            chk({tag, " oe"}, {31'd0, mdio_oe}, {31'd0, e_oe});
            chk({tag, " mdio_o"}, {31'd0, mdio_o}, {31'd0, e_mdo});
            chk("R2 busy", {31'd0, busy}, {31'd0, m_active});
            chk("R9 done", {31'd0, done}, {31'd0, m_done});
            if (m_done) chk("R8 rd_data", {16'd0, rd_data}, {16'd0, m_rd});
            else        chk("R9 rd_data hold", {16'd0, rd_data}, {16'd0, m_rd});
        end
    end

    task automatic launch(input bit pre, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, input logic [3:0] j);
        preamble_on = pre;
        phy_addr    = pa;
        reg_addr    = ra;
        nx_data     = d;
        nx_junk     = j;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!m_done);
    endtask

    task automatic txn(input bit pre, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] d, input logic [3:0] j);
        launch(pre, pa, ra, d, j);
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; preamble_on = 1'b0;
        phy_addr = '0; reg_addr = '0; mdio_i = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mdc", {31'd0, mdc}, 32'd0);
        chk("R1 reset oe", {31'd0, mdio_oe}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset rd_data", {16'd0, rd_data}, 32'd0);

        txn(1'b1, 5'd1,  5'd2,  16'hA5C3, 4'b1010);
        txn(1'b0, 5'd31, 5'd31, 16'hFFFF, 4'b0000);
        txn(1'b1, 5'd0,  5'd0,  16'h0000, 4'b1111);
        txn(1'b0, 5'd9,  5'd17, 16'h1234, 4'b0110);

        // R3: a second request and changed inputs in mid frame
        launch(1'b0, 5'd3, 5'd4, 16'h5A0F, 4'b1001);
        repeat (BIT_CYC * 5) @(negedge clk);
        preamble_on = 1'b1; phy_addr = 5'h1F; reg_addr = 5'h00;
        nx_data = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (BIT_CYC * 12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R3 rd_data after ignored start", {16'd0, rd_data}, 32'h5A0F);
        @(negedge clk);

        // R10: request in the done cycle
        launch(1'b1, 5'd12, 5'd6, 16'hC001, 4'b0101);
        wait_done();
        launch(1'b0, 5'd21, 5'd10, 16'h7E81, 4'b1100);
        chk("R10 busy after start in done cycle", {31'd0, busy}, 32'd1);
        chk("R10 previous result kept", {16'd0, rd_data}, 32'hC001);
        wait_done();
        chk("R10 second result", {16'd0, rd_data}, 32'h7E81);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, no completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule